// File: doc/BRIEF.md
# E3 Transmit Payload Input Interface

This block takes outbound payload from terminal equipment and passes it to an E3 framer as a stream of qualified bits, one bit per bit period. The terminal side is serial (one bit per bit period) or nibble-wide (four bits every fourth bit period). The bit period comes from one of two timing sources, each presented as a single-cycle tick on the block's core clock. In loop timing the tick from the recovered receive clock paces the block. In local timing the tick from the local transmit clock paces it. Under local timing the block either decides where frames begin (frame master) or follows a frame-start strobe from the terminal equipment (frame slave). Together these choices give six operating modes.

The block keeps a bit-position counter across the frame. It tells the terminal equipment when it captures data with a strobe, which stands in for the forwarded interface clock edge. It marks the final bit of each frame with a one-bit-period pulse. It flags the leading overhead bit positions, and during those positions the terminal data is ignored. A new mode setting is taken only at the start of a frame.

Top module: `e3tx_payload_in`

## Requirements
- R1: The mode is set by three inputs: `cfg_nibble` (1 = 4-bit input, 0 = serial), `cfg_loop` (1 = loop timing, 0 = local timing) and `cfg_master` (1 = frame master). `cfg_master` has meaning only when `cfg_loop` is 0. These give six distinct modes.
- R2: With loop timing, each bit period is paced by `rx_clk_tick` and `tx_clk_tick` is ignored. With local timing the roles are swapped.
- R3: `fr_bit_valid` is high for exactly the one clock cycle that follows each selected tick, and never otherwise.
- R4: `te_clk_strobe` is high in the cycle after a tick at which terminal data is captured. In serial mode that is every tick. In nibble mode it is only the ticks at bit positions that are multiples of 4.
- R5: In serial mode, `fr_bit` equals `te_ser` as sampled at the tick.
- R6: In nibble mode, `te_nib` is captured at the tick of a position that is a multiple of 4. Its bits go out most significant first: `te_nib[3]`, then [2], [1] and [0] over four consecutive ticks.
- R7: `te_frame_end` is high for exactly one bit period (from one tick's update to the next), and only for the bit at position FRAME_BITS-1 (default 1535).
- R8: `te_overhead` is high for the bits at positions 0 to OH_BITS-1 (default 0..11). For those bits `fr_bit` is 0 whatever the terminal data.
- R9: In frame-slave mode (local timing, `cfg_master` = 0), `te_frame_start` high at a tick sends the next bit to position 0. In the other modes the input has no effect.
- R10: Without a restart, the position counter advances by one per tick and wraps from FRAME_BITS-1 to 0.
- R11: The mode inputs are sampled only at a tick where the position is 0. Changes made at any other time take effect at the next frame start.
- R12: While `rst_n` is low, all outputs are 0 and the position is 0. The first bit after reset is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nibble | input | 1 | 1 = nibble-wide terminal input |
| cfg_loop | input | 1 | 1 = pace from recovered receive clock |
| cfg_master | input | 1 | 1 = block decides frame starts (local timing) |
| rx_clk_tick | input | 1 | One-cycle tick per recovered-clock bit period |
| tx_clk_tick | input | 1 | One-cycle tick per local-clock bit period |
| te_frame_start | input | 1 | Frame-start strobe from terminal equipment |
| te_ser | input | 1 | Serial payload bit |
| te_nib | input | NIB_W | Nibble payload, bit NIB_W-1 sent first |
| te_clk_strobe | output | 1 | Capture strobe toward terminal equipment |
| te_frame_end | output | 1 | Last bit of frame marker |
| te_overhead | output | 1 | Overhead bit position marker |
| fr_bit_valid | output | 1 | Bit qualifier toward framer |
| fr_bit | output | 1 | Payload bit toward framer |

## Verification
The bench collides functions in two places. The first is a frame-start strobe on a tick that also wraps or splits a nibble. The slave scenarios place the strobe in the middle of a nibble and on the final bit. The bench model requires the counter restart to win, the nibble remainder to be dropped, and position 0 to read as overhead. The second is a mode change written mid-frame. It must wait for the frame boundary, so the capture strobe rate, the data source and the pacing tick must all stay on the old mode until that boundary.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;

  typedef struct packed {
    logic nibble;
    logic loop;
    logic master;
  } e3tx_mode_t;

  // frame slave exists only under local timing
  function automatic logic f_is_slave(e3tx_mode_t m);
    return !m.loop && !m.master;
  endfunction

  function automatic logic f_is_overhead(int unsigned pos, int unsigned oh_bits);
    return pos < oh_bits;
  endfunction

  function automatic int unsigned f_nib_phase(int unsigned pos, int unsigned nib_w);
    return pos % nib_w;
  endfunction

  function automatic int unsigned f_next_pos(int unsigned pos, int unsigned frame_bits,
                                             logic restart);
    if (restart) return 0;
    return (pos + 1 == frame_bits) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/e3tx_mode_ctl.sv
module e3tx_mode_ctl
  import e3tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  e3tx_mode_t mode_in,
  input  logic       at_start,
  input  logic       rx_tick,
  input  logic       tx_tick,
  output e3tx_mode_t mode_eff,
  output e3tx_mode_t mode_held,
  output logic       tick
);

  e3tx_mode_t held_q;

  // new configuration is admitted only at frame position zero
  assign mode_eff  = at_start ? mode_in : held_q;
  assign mode_held = held_q;
  assign tick      = mode_eff.loop ? rx_tick : tx_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (tick) held_q <= mode_eff;
  end

endmodule

// File: rtl/e3tx_pos_ctr.sv
module e3tx_pos_ctr
  import e3tx_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  output logic [PW-1:0] pos,
  output logic          at_start,
  output logic          at_last
);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (tick) pos_q <= PW'(f_next_pos(32'(pos_q), FRAME_BITS, restart));
  end

  assign pos      = pos_q;
  assign at_start = (pos_q == '0);
  assign at_last  = (32'(pos_q) == FRAME_BITS - 1);

endmodule

// File: rtl/e3tx_lane.sv
module e3tx_lane #(
  parameter int NIB_W = 4,
  parameter int SHW   = NIB_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             nibble,
  input  logic             phase0,
  input  logic             overhead,
  input  logic             ser_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             bit_next,
  output logic             capture
);

  logic [SHW-1:0] sh_q;
  logic           raw;

  // remaining nibble bits wait here, top bit first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (tick && nibble) begin
      if (phase0) sh_q <= nib_in[SHW-1:0];
      else        sh_q <= {sh_q[SHW-2:0], 1'b0};
    end
  end

  always_comb begin
    if (!nibble)     raw = ser_in;
    else if (phase0) raw = nib_in[NIB_W-1];
    else             raw = sh_q[SHW-1];
  end

  assign bit_next = overhead ? 1'b0 : raw;
  assign capture  = tick && (!nibble || phase0);

endmodule

// File: rtl/e3tx_payload_in.sv
module e3tx_payload_in
  import e3tx_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int OH_BITS    = 12,
  parameter int NIB_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_nibble,
  input  logic             cfg_loop,
  input  logic             cfg_master,
  input  logic             rx_clk_tick,
  input  logic             tx_clk_tick,
  input  logic             te_frame_start,
  input  logic             te_ser,
  input  logic [NIB_W-1:0] te_nib,
  output logic             te_clk_strobe,
  output logic             te_frame_end,
  output logic             te_overhead,
  output logic             fr_bit_valid,
  output logic             fr_bit
);

  localparam int PW = $clog2(FRAME_BITS);

  e3tx_mode_t    mode_in, mode_eff, mode_held;
  logic          tick_sel, restart, at_start, at_last;
  logic          phase0, overhead, bit_next, capture;
  logic [PW-1:0] pos_q;

  assign mode_in = '{nibble: cfg_nibble, loop: cfg_loop, master: cfg_master};

  e3tx_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_in  (mode_in),
    .at_start (at_start),
    .rx_tick  (rx_clk_tick),
    .tx_tick  (tx_clk_tick),
    .mode_eff (mode_eff),
    .mode_held(mode_held),
    .tick     (tick_sel)
  );

  assign restart = f_is_slave(mode_eff) && te_frame_start;

  e3tx_pos_ctr #(.FRAME_BITS(FRAME_BITS), .PW(PW)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_sel),
    .restart (restart),
    .pos     (pos_q),
    .at_start(at_start),
    .at_last (at_last)
  );

  assign phase0   = (f_nib_phase(32'(pos_q), NIB_W) == 0);
  assign overhead = f_is_overhead(32'(pos_q), OH_BITS);

  e3tx_lane #(.NIB_W(NIB_W)) u_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_sel),
    .nibble  (mode_eff.nibble),
    .phase0  (phase0),
    .overhead(overhead),
    .ser_in  (te_ser),
    .nib_in  (te_nib),
    .bit_next(bit_next),
    .capture (capture)
  );

  // markers describe the bit just issued and hold for its whole period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_bit_valid  <= 1'b0;
      fr_bit        <= 1'b0;
      te_clk_strobe <= 1'b0;
      te_frame_end  <= 1'b0;
      te_overhead   <= 1'b0;
    end else begin
      fr_bit_valid  <= tick_sel;
      te_clk_strobe <= capture;
      if (tick_sel) begin
        fr_bit       <= bit_next;
        te_frame_end <= at_last;
        te_overhead  <= overhead;
      end
    end
  end

endmodule

// File: rtl/e3tx_payload_in_chk.sv
module e3tx_payload_in_chk
  import e3tx_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int PW         = $clog2(FRAME_BITS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_sel,
  input logic          restart,
  input logic          at_start,
  input logic          at_last,
  input logic [PW-1:0] pos_q,
  input e3tx_mode_t    mode_eff,
  input e3tx_mode_t    mode_held,
  input logic          te_frame_start,
  input logic          te_clk_strobe,
  input logic          te_frame_end,
  input logic          te_overhead,
  input logic          fr_bit_valid,
  input logic          fr_bit
);

  AST_VALID_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fr_bit_valid == $past(tick_sel))); // R3

  AST_STROBE_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    te_clk_strobe |-> fr_bit_valid); // R4

  AST_OH_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_bit_valid && te_overhead) |-> !fr_bit); // R8

  AST_MARKERS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !fr_bit_valid) |-> ($stable(te_frame_end) && $stable(te_overhead))); // R7

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel && at_last) |=> (pos_q == '0)); // R10

  AST_SLAVE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel && !mode_eff.loop && !mode_eff.master && te_frame_start) |=> at_start); // R9

  AST_MODE_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel && !at_start) |=> $stable(mode_held)); // R11

endmodule

bind e3tx_payload_in e3tx_payload_in_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_sel      (tick_sel),
  .restart       (restart),
  .at_start      (at_start),
  .at_last       (at_last),
  .pos_q         (pos_q),
  .mode_eff      (mode_eff),
  .mode_held     (mode_held),
  .te_frame_start(te_frame_start),
  .te_clk_strobe (te_clk_strobe),
  .te_frame_end  (te_frame_end),
  .te_overhead   (te_overhead),
  .fr_bit_valid  (fr_bit_valid),
  .fr_bit        (fr_bit)
);

// File: tb/e3tx_payload_in_tb.sv
`timescale 1ns/1ps
module e3tx_payload_in_tb;

  localparam int FB = 1536;
  localparam int OH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_nibble = 1'b0, cfg_loop = 1'b1, cfg_master = 1'b1;
  logic rx_clk_tick = 1'b0, tx_clk_tick = 1'b0, te_frame_start = 1'b0, te_ser = 1'b0;
  logic [3:0] te_nib = '0;
  logic te_clk_strobe, te_frame_end, te_overhead, fr_bit_valid, fr_bit;

  always #2.5 clk = ~clk;

  e3tx_payload_in u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_nibble(cfg_nibble), .cfg_loop(cfg_loop),
    .cfg_master(cfg_master), .rx_clk_tick(rx_clk_tick), .tx_clk_tick(tx_clk_tick),
    .te_frame_start(te_frame_start), .te_ser(te_ser), .te_nib(te_nib),
    .te_clk_strobe(te_clk_strobe), .te_frame_end(te_frame_end),
    .te_overhead(te_overhead), .fr_bit_valid(fr_bit_valid), .fr_bit(fr_bit)
  );

  int total = 0, failed = 0, cyc = 0, wd = 0;

  // bench model state
  int       m_pos = 0;
  logic [2:0] m_held = 3'b000;   // {nibble, loop, master}
  logic [3:0] m_nib = '0;
  logic e_valid = 0, e_tclk = 0, e_fe = 0, e_oh = 0, e_data = 0, e_nibmode = 0;
  logic [2:0] s_mode = 3'b011;
  logic [7:0] s_pat = 8'h00;
  int       s_sof_at = 0;
  logic     s_sof_done = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0b expected=%0b cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  // one clock: check what the previous edge produced, then drive and predict
  task automatic cycle_once(input logic release_rst);
    logic [2:0] eff;
    logic tk, b, ph0;
    int ph;
    @(negedge clk);
    if (!rst_n) begin
      chk("R12 valid in reset", fr_bit_valid, 1'b0);
      chk("R12 strobe in reset", te_clk_strobe, 1'b0);
      chk("R12 frame_end in reset", te_frame_end, 1'b0);
      chk("R12 overhead in reset", te_overhead, 1'b0);
      chk("R12 data in reset", fr_bit, 1'b0);
    end else begin
      chk("R2 R3 bit_valid", fr_bit_valid, e_valid);
      chk("R4 capture strobe", te_clk_strobe, e_tclk);
      chk("R7 R10 frame_end", te_frame_end, e_fe);
      chk("R8 R9 R11 overhead", te_overhead, e_oh);
      if (e_valid)
        chk(e_nibmode ? "R1 R6 R8 nibble data" : "R1 R5 R8 serial data", fr_bit, e_data);
    end
    if (release_rst) rst_n = 1'b1;
    cyc++;
    rx_clk_tick    = (cyc % 2 == 0);
    tx_clk_tick    = (cyc % 3 != 0);
    te_ser         = s_pat[cyc % 8];
    te_nib         = 4'(cyc) ^ s_pat[7:4];
    te_frame_start = (s_sof_at != 0) && !s_sof_done && (m_pos == s_sof_at);
    {cfg_nibble, cfg_loop, cfg_master} = s_mode;
    if (rst_n) begin
      eff = (m_pos == 0) ? s_mode : m_held;
      tk  = eff[1] ? rx_clk_tick : tx_clk_tick;
      ph  = m_pos % 4;
      ph0 = (ph == 0);
      e_valid = tk;
      e_tclk  = tk && (!eff[2] || ph0);
      if (tk) begin
        m_held = eff;
        e_nibmode = eff[2];
        e_oh = (m_pos < OH);
        e_fe = (m_pos == FB - 1);
        if (eff[2]) begin
          if (ph0) m_nib = te_nib;
          b = m_nib[3 - ph];
        end else b = te_ser;
        e_data = e_oh ? 1'b0 : b;
        if (te_frame_start) s_sof_done = 1'b1;
        if (!eff[1] && !eff[0] && te_frame_start) m_pos = 0;
        else m_pos = (m_pos == FB - 1) ? 0 : m_pos + 1;
      end
    end
  endtask

  task automatic model_reset();
    m_pos = 0; m_held = 3'b000; m_nib = '0;
    e_valid = 0; e_tclk = 0; e_fe = 0; e_oh = 0; e_data = 0;
  endtask

  // {mode nibble/loop/master, pattern, frame-start position (0 = none), cycles}
  // R1: all six modes; R9: strobe applied in every mode, honoured only in slave
  localparam logic [38:0] VEC [0:7] = '{
    {3'b010, 8'hFF, 12'd700,  16'd4000},  // serial loop, all-ones vs overhead mask
    {3'b000, 8'hA5, 12'd900,  16'd5000},  // serial slave, restart
    {3'b001, 8'h3C, 12'd800,  16'd4000},  // serial master, strobe ignored
    {3'b110, 8'hF0, 12'd500,  16'd4000},  // nibble loop, strobe ignored
    {3'b100, 8'h96, 12'd1001, 16'd5000},  // nibble slave, restart mid-nibble
    {3'b101, 8'h5A, 12'd0,    16'd4000},  // nibble master
    {3'b000, 8'hC3, 12'd1535, 16'd3500},  // serial slave, restart on last bit
    {3'b011, 8'h69, 12'd0,    16'd3000}   // serial loop again; R11 change lands mid-frame
  };

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failed++; total++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) cycle_once(1'b0);           // R12 reset state
    cycle_once(1'b1);
    for (int i = 0; i < 8; i++) begin
      s_mode     = VEC[i][38:36];
      s_pat      = VEC[i][35:28];
      s_sof_at   = int'(VEC[i][27:16]);
      s_sof_done = 1'b0;
      for (int c = 0; c < int'(VEC[i][15:0]); c++) cycle_once(1'b0);
    end
    // R12: reset in mid-frame of nibble slave, counter restarts at zero
    s_mode = 3'b100; s_pat = 8'h77; s_sof_at = 0;
    repeat (1300) cycle_once(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (3) cycle_once(1'b0);
    cycle_once(1'b1);
    repeat (3400) cycle_once(1'b0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule